// File: doc/BRIEF.md
# Motor Stall Detection Controller

This block decides when a brushed DC motor has stalled. It watches a comparator flag that goes high when the sensed bridge current is at or above a trip reference. It also watches the two bridge direction inputs. Whenever the motor is started from the idle state, where both direction inputs are low, it opens a blanking window. During that window the comparator is ignored, so that inrush current is not taken for a stall. The window also restarts on power-up, on a wake-from-sleep event, on a fault-recovery event and on release from a stall.

A two-bit mode code selects the response to a stall. In latched mode the bridge outputs are switched off and the active-low stall flag is held low. The only way out is a sleep interval, in which both direction inputs stay low. In the two indication-only modes the bridge keeps driving and only the flag is pulled low. The flag is released after a shorter retry interval, provided the comparator is quiet by then. One of the indication-only modes also selects the fixed internal trip reference instead of the external one. A strap sampled right after reset turns stall detection off entirely.

Top module: `stall_guard`

## Requirements
- R1: Blanking starts (or restarts) when the synchronised direction inputs change from both-low to any other value. A change between two non-idle values does not restart it, so an over-threshold flag present after the window has expired is reported within a few cycles.
- R2: A one-cycle pulse on `wake_evt` or `fault_clr` restarts blanking. For BLANK_CYCLES after the pulse, an over-threshold flag causes no stall. Reset (power-up) also starts a window.
- R3: A stall is declared only while the motor runs, the blanking window has fully elapsed and the synchronised comparator flag is high. With the flag high from start-up, `stall_n` is still 1 at BLANK_CYCLES+2 cycles after the start and is 0 by BLANK_CYCLES+6 cycles.
- R4: With `mode_code` = 2'b00 (latched), a stall drives `stall_n` low and `bridge_en` low.
- R5: In latched mode the stall is held until both direction inputs have been low for SLEEP_CYCLES. It is not released at the retry interval. After release, `stall_n` and `bridge_en` both return to 1.
- R6: With `mode_code` = 2'b01 (indicate), a stall drives `stall_n` low while `bridge_en` stays 1.
- R7: With `mode_code` = 2'b10 or 2'b11 (indicate, internal reference), `ref_int` is 1 and a stall behaves as in R6. In the other two modes `ref_int` is 0.
- R8: In the indication modes the flag is released once both direction inputs have been low for RETRY_CYCLES and the comparator flag is low. It stays low while the comparator is high. If the comparator is high when the motor restarts, the flag is asserted again after a fresh blanking window.
- R9: RETRY_CYCLES is smaller than SLEEP_CYCLES, so an indication-mode release happens before the latched-mode release point.
- R10: If `strap_en` is 0 in the first cycle after reset, no stall is ever declared: `stall_n` and `bridge_en` stay 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| dir_a | input | 1 | First bridge direction input, asynchronous |
| dir_b | input | 1 | Second bridge direction input, asynchronous |
| over_trip | input | 1 | Comparator flag, 1 when current is at or above the trip level; asynchronous |
| mode_code | input | 2 | Stall response: 00 latched, 01 indicate, 1x indicate with internal reference |
| strap_en | input | 1 | Detection enable strap, sampled once after reset |
| wake_evt | input | 1 | Synchronous pulse: device has left sleep |
| fault_clr | input | 1 | Synchronous pulse: device has recovered from a fault |
| stall_n | output | 1 | Active-low stall flag |
| bridge_en | output | 1 | Bridge output enable |
| ref_int | output | 1 | 1 selects the fixed internal trip reference |

## Verification
The bench builds the block with BLANK_CYCLES = 40, RETRY_CYCLES = 20 and SLEEP_CYCLES = 60. With these values every window expires within a few dozen cycles, so each scenario can check both sides of a window edge. The retry point and the sleep point are 40 cycles apart, which lets one idle stretch show a release in the indication modes and no release in latched mode. Four cycles of margin around each edge cover the two-stage synchronisers.

// File: rtl/stall_guard.sv
module stall_guard #(
  parameter int BLANK_CYCLES = 1000,
  parameter int RETRY_CYCLES = 200,
  parameter int SLEEP_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_a,
  input  logic       dir_b,
  input  logic       over_trip,
  input  logic [1:0] mode_code,
  input  logic       strap_en,
  input  logic       wake_evt,
  input  logic       fault_clr,
  output logic       stall_n,
  output logic       bridge_en,
  output logic       ref_int
);
  localparam int BW = $clog2(BLANK_CYCLES + 1);
  localparam int IW = $clog2(SLEEP_CYCLES + 1);
  localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYCLES);
  localparam logic [IW-1:0] RETRY_END  = IW'(RETRY_CYCLES);
  localparam logic [IW-1:0] SLEEP_END  = IW'(SLEEP_CYCLES);
  localparam logic [1:0]    MODE_LATCH = 2'b00;

  logic [1:0]    a_sync, b_sync, o_sync;
  logic          run_d, en_q, strap_done, stall_q, lat_q;
  logic [BW-1:0] blank_cnt;
  logic [IW-1:0] idle_cnt;

  wire run     = a_sync[1] | b_sync[1];
  wire start   = run & ~run_d;
  wire over    = o_sync[1];
  wire release_now = stall_q & ~run &
                     (lat_q ? (idle_cnt >= SLEEP_END)
                            : (idle_cnt >= RETRY_END && !over));
  wire restart = start | wake_evt | fault_clr | release_now;
  wire detect  = en_q & run & (blank_cnt == '0) & over & ~stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync     <= '0;
      b_sync     <= '0;
      o_sync     <= '0;
      run_d      <= 1'b0;
      en_q       <= 1'b0;
      strap_done <= 1'b0;
      blank_cnt  <= BLANK_LOAD;
      idle_cnt   <= '0;
      stall_q    <= 1'b0;
      lat_q      <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], dir_a};
      b_sync <= {b_sync[0], dir_b};
      o_sync <= {o_sync[0], over_trip};
      run_d  <= run;
      if (!strap_done) begin
        en_q       <= strap_en;
        strap_done <= 1'b1;
      end
      if (restart)
        blank_cnt <= BLANK_LOAD;
      else if (blank_cnt != '0)
        blank_cnt <= blank_cnt - 1'b1;
      if (run)
        idle_cnt <= '0;
      else if (idle_cnt < SLEEP_END)
        idle_cnt <= idle_cnt + 1'b1;
      if (detect) begin
        stall_q <= 1'b1;
        lat_q   <= (mode_code == MODE_LATCH);
      end else if (release_now) begin
        stall_q <= 1'b0;
        lat_q   <= 1'b0;
      end
    end
  end

  assign stall_n   = ~stall_q;
  assign bridge_en = ~lat_q;
  assign ref_int   = mode_code[1];

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> blank_cnt == BLANK_LOAD); // R1
  AST_EVENT_REBLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt || fault_clr) |=> blank_cnt == BLANK_LOAD); // R2
  AST_AFTER_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> ($past(blank_cnt) == '0 && $past(over))); // R3
  AST_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall_q) && $past(mode_code) == MODE_LATCH) |-> !bridge_en); // R4
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_q) |-> $past(!run)); // R5
  AST_FLAG_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stall_q) && $past(mode_code) != MODE_LATCH) |-> bridge_en); // R6
  AST_RETRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall_q) && $past(!lat_q)) |-> $past(!over)); // R8
  AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && !en_q) |-> stall_n); // R10
endmodule

// File: tb/sim_stall_guard.sv
module sim_stall_guard;
  localparam int BLANK = 40;
  localparam int RETRY = 20;
  localparam int SLEEP = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 1'b0, dir_b = 1'b0, over_trip = 1'b0;
  logic [1:0] mode_code = 2'b00;
  logic strap_en = 1'b1, wake_evt = 1'b0, fault_clr = 1'b0;
  logic stall_n, bridge_en, ref_int;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  stall_guard #(.BLANK_CYCLES(BLANK), .RETRY_CYCLES(RETRY), .SLEEP_CYCLES(SLEEP)) u0 (
    .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b), .over_trip(over_trip),
    .mode_code(mode_code), .strap_en(strap_en), .wake_evt(wake_evt),
    .fault_clr(fault_clr), .stall_n(stall_n), .bridge_en(bridge_en), .ref_int(ref_int));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m, input logic s);
    @(negedge clk);
    rst_n = 1'b0; dir_a = 1'b0; dir_b = 1'b0; over_trip = 1'b0;
    mode_code = m; strap_en = s; wake_evt = 1'b0; fault_clr = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic pulse_evt(input bit wake);
    if (wake) wake_evt = 1'b1; else fault_clr = 1'b1;
    cyc(1);
    wake_evt = 1'b0; fault_clr = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset(2'b00, 1'b1);
    chk("R4 reset stall_n", stall_n, 1'b1);
    chk("R4 reset bridge_en", bridge_en, 1'b1);
    chk("R7 reset ref_int mode00", ref_int, 1'b0);
  endtask

  task automatic t_blank_latch();
    do_reset(2'b00, 1'b1);
    over_trip = 1'b1; dir_a = 1'b1;
    cyc(BLANK + 2);
    chk("R3 inside blank", stall_n, 1'b1);
    chk("R3 bridge on in blank", bridge_en, 1'b1);
    cyc(4);
    chk("R3 stall after blank", stall_n, 1'b0);
    chk("R4 latched bridge off", bridge_en, 1'b0);
    dir_a = 1'b0; over_trip = 1'b0;
    cyc(RETRY + 6);
    chk("R5 no release at retry", stall_n, 1'b0);
    cyc(SLEEP - RETRY - 8);
    chk("R5 held before sleep", stall_n, 1'b0);
    cyc(10);
    chk("R5 released after sleep", stall_n, 1'b1);
    chk("R5 bridge back on", bridge_en, 1'b1);
  endtask

  task automatic t_indicate(input logic [1:0] m, input logic exp_ref);
    do_reset(m, 1'b1);
    chk("R7 ref_int", ref_int, exp_ref);
    over_trip = 1'b1; dir_b = 1'b1;
    cyc(BLANK + 6);
    chk("R6 stall flagged", stall_n, 1'b0);
    chk("R6 bridge keeps driving", bridge_en, 1'b1);
    dir_b = 1'b0;
    cyc(RETRY + 8);
    chk("R8 held while over", stall_n, 1'b0);
    over_trip = 1'b0;
    cyc(5);
    chk("R8 released when quiet", stall_n, 1'b1);
    chk("R9 retry release before sleep", stall_n, 1'b1);
    over_trip = 1'b1; dir_a = 1'b1;
    cyc(BLANK + 2);
    chk("R8 reblank after restart", stall_n, 1'b1);
    cyc(4);
    chk("R8 reasserted", stall_n, 1'b0);
    dir_a = 1'b0; over_trip = 1'b0;
    cyc(RETRY + 6);
    chk("R9 quiet release at retry", stall_n, 1'b1);
  endtask

  task automatic t_no_restart();
    do_reset(2'b01, 1'b1);
    dir_a = 1'b1;
    cyc(BLANK + 10);
    dir_a = 1'b0; dir_b = 1'b1;
    cyc(1);
    over_trip = 1'b1;
    cyc(6);
    chk("R1 direction swap does not reblank", stall_n, 1'b0);
  endtask

  task automatic t_event(input bit wake);
    do_reset(2'b01, 1'b1);
    dir_a = 1'b1;
    cyc(BLANK + 10);
    pulse_evt(wake);
    over_trip = 1'b1;
    cyc(BLANK - 4);
    chk(wake ? "R2 wake reblank" : "R2 fault reblank", stall_n, 1'b1);
    cyc(10);
    chk(wake ? "R2 stall after wake window" : "R2 stall after fault window", stall_n, 1'b0);
  endtask

  task automatic t_strap_off();
    do_reset(2'b00, 1'b0);
    over_trip = 1'b1; dir_a = 1'b1;
    cyc(BLANK * 3);
    chk("R10 disabled no stall", stall_n, 1'b1);
    chk("R10 disabled bridge on", bridge_en, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_blank_latch();
        t_indicate(2'b01, 1'b0);
        t_indicate(2'b10, 1'b1);
        t_indicate(2'b11, 1'b1);
        t_no_restart();
        t_event(1'b1);
        t_event(1'b0);
        t_strap_off();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule